// File: doc/BRIEF.md
# External Trigger Timestamp and Event Unit

This block sits beside a free-running 64-bit time counter. It watches two asynchronous trigger pins. When a pin shows its chosen edge, the block copies the counter value into a capture register pair dedicated to that pin. It also raises a sticky event flag for that pin.

The same event register gathers single-cycle strobes from the alarm comparators and the periodic pulse generators. Software acknowledges events by writing ones to the event register. A mask register decides which pending events drive the single interrupt line.

Each trigger pin passes through a two-flop synchroniser before its edge detector. Software therefore sees a capture a fixed number of cycles after the pin moves. A later edge on a pin replaces that pin's earlier capture, whether or not software has read it.

Top module: `ext_ts_event_unit`

## Requirements
- R1: After a clock edge with `rst_n` low, both capture pairs, the event register and the mask register read zero, and `irq` is low.
- R2: Each trigger pin goes through two synchronising flops and then an edge detector. Take a pin change first sampled at clock edge k. The capture and its event bit are updated at edge k+2 and not earlier.
- R3: On a detected edge of trigger t, `cap_hi[t]` takes `cur_time[63:32]` and `cap_lo[t]` takes `cur_time[31:0]`, as sampled at the updating edge. With no detected edge, the pair holds its value.
- R4: Input `trig_fall[t]` selects the active edge of trigger t: 0 means rising and 1 means falling. The other edge is ignored.
- R5: The event register sets bit 24 for a trigger 0 capture and bit 25 for a trigger 1 capture. It sets bit 16 for `alarm_hit[0]`, bit 17 for `alarm_hit[1]`, bit 7 for `pulse_hit[0]` and bit 6 for `pulse_hit[1]`. Set bits stay set, and all other bits read zero.
- R6: A write with `wr_sel`=0 clears each event bit whose `wr_data` bit is one. Bits written with zero are unchanged, and the mask register is untouched.
- R7: A write with `wr_sel`=1 replaces the mask register with `wr_data`, restricted to bits 25, 24, 17, 16, 7 and 6. Other mask bits read zero, and the event register is untouched.
- R8: `irq` is high in exactly those cycles where some event bit and the mask bit at the same position are both set. A cleared mask bit keeps its event from the interrupt.
- R9: When an event strobe or capture falls in the same cycle as a write clearing that bit, the bit ends set.
- R10: A new detected edge on a trigger overwrites that trigger's capture pair, even if the previous value was never read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_pin | input | 2 | Asynchronous external trigger pins |
| trig_fall | input | 2 | Per-trigger edge select, 1 = falling |
| cur_time | input | 64 | Current time from the time counter |
| alarm_hit | input | 2 | Single-cycle alarm match strobes |
| pulse_hit | input | 2 | Single-cycle periodic pulse strobes |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 event (write-one-to-clear), 1 mask |
| wr_data | input | 32 | Write data |
| cap_hi | output | 2x32 | Captured time, upper word, per trigger |
| cap_lo | output | 2x32 | Captured time, lower word, per trigger |
| evt_reg | output | 32 | Sticky event register |
| mask_reg | output | 32 | Event mask register |
| irq | output | 1 | Masked interrupt |

## Verification
Two functions can land in the same cycle: setting an event bit, and a software write clearing that same bit. The bench times a trigger pin change so that the write-one-to-clear lands exactly on the edge where the capture updates. It also places an alarm strobe in the same cycle as a clear of its bit. In both cases the event bit must read set afterwards. A behavioural model updated on every clock judges the outcome, and directed checks with literal values confirm it.

// File: rtl/tsu_evt_pkg.sv
// Package: shared parameters, bit positions and register select encoding
// for the external trigger timestamp and event unit.
package tsu_evt_pkg;
    localparam int WORD_W    = 32;
    localparam int TIME_W    = 64;
    localparam int NUM_TRIG  = 2;
    localparam int NUM_ALARM = 2;
    localparam int NUM_PULSE = 2;
    localparam int SYNC_LEN  = 2;

    typedef enum logic {
        SEL_EVENT = 1'b0,
        SEL_MASK  = 1'b1
    } reg_sel_e;

    // Event bit of trigger i.
    function automatic int trig_bit(input int i);
        return 24 + i;
    endfunction

    // Event bit of alarm i.
    function automatic int alarm_bit(input int i);
        return 16 + i;
    endfunction

    // Event bit of pulse channel i (channel 0 is the higher bit).
    function automatic int pulse_bit(input int i);
        return 7 - i;
    endfunction

    // Vector of all implemented event and mask positions.
    function automatic logic [WORD_W-1:0] impl_bits();
        logic [WORD_W-1:0] v;
        v = '0;
        for (int i = 0; i < NUM_TRIG; i++)  v[trig_bit(i)]  = 1'b1;
        for (int i = 0; i < NUM_ALARM; i++) v[alarm_bit(i)] = 1'b1;
        for (int i = 0; i < NUM_PULSE; i++) v[pulse_bit(i)] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/tsu_trig_detect.sv
// Module: tsu_trig_detect
// Synchronises one asynchronous trigger pin through SYNC_LEN flops and
// emits a one-cycle pulse on the selected edge.
// Assumes: the pin is held longer than a clock period per level, and
// fall_sel is quasi-static relative to trigger activity.
module tsu_trig_detect #(
    parameter int SYNC_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_pulse
);
    logic [SYNC_LEN-1:0] sync_q;
    logic                last_q;
    logic                level;

    assign level = sync_q[SYNC_LEN-1];

    // Shift the pin through the synchroniser chain and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_LEN-2:0], pin};
            last_q <= level;
        end
    end

    // Compare the synchronised level with its previous value for the chosen edge.
    always_comb begin
        if (fall_sel) edge_pulse = last_q & ~level;
        else          edge_pulse = level & ~last_q;
    end
endmodule

// File: rtl/tsu_capture.sv
// Module: tsu_capture
// Holds one captured time value, split into upper and lower words.
// Assumes: load is a single-cycle pulse; a new load simply overwrites.
module tsu_capture #(
    parameter int TIME_W = 64,
    parameter int WORD_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [TIME_W-1:0]        time_in,
    output logic [TIME_W-WORD_W-1:0] cap_hi,
    output logic [WORD_W-1:0]        cap_lo
);
    localparam int HI_W = TIME_W - WORD_W;

    // Latch both words of the current time on a load pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_hi <= '0;
            cap_lo <= '0;
        end else if (load) begin
            cap_hi <= time_in[TIME_W-1 -: HI_W];
            cap_lo <= time_in[WORD_W-1:0];
        end
    end
endmodule

// File: rtl/tsu_event_regs.sv
// Module: tsu_event_regs
// Sticky event register with write-one-to-clear, a mask register and the
// masked interrupt. New events win over a clear in the same cycle.
// Assumes: set_vec carries single-cycle strobes at implemented positions.
module tsu_event_regs
    import tsu_evt_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         clr_wr,
    input  logic         mask_wr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] evt_q,
    output logic [W-1:0] mask_q,
    output logic         irq
);
    localparam logic [W-1:0] IMPL = W'(impl_bits());

    logic [W-1:0] clr_vec;
    logic [W-1:0] evt_d;
    logic [W-1:0] mask_d;

    // Build the clear vector and next-state values for both registers.
    always_comb begin
        clr_vec = clr_wr ? wr_data : '0;
        evt_d   = ((evt_q & ~clr_vec) | set_vec) & IMPL;
        mask_d  = mask_wr ? (wr_data & IMPL) : mask_q;
    end

    // Register the event and mask state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q  <= '0;
            mask_q <= '0;
        end else begin
            evt_q  <= evt_d;
            mask_q <= mask_d;
        end
    end

    // Reduce the pending-and-enabled events to the interrupt line.
    always_comb begin
        irq = |(evt_q & mask_q);
    end
endmodule

// File: rtl/ext_ts_event_unit.sv
// Module: ext_ts_event_unit (top)
// Captures cur_time on selected edges of two trigger pins, and gathers
// trigger, alarm and pulse events into a sticky masked event register.
// Assumes: cur_time is synchronous to clk; strobes are one cycle wide.
module ext_ts_event_unit
    import tsu_evt_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_TRIG-1:0]              trig_pin,
    input  logic [NUM_TRIG-1:0]              trig_fall,
    input  logic [TIME_W-1:0]                cur_time,
    input  logic [NUM_ALARM-1:0]             alarm_hit,
    input  logic [NUM_PULSE-1:0]             pulse_hit,
    input  logic                             wr_en,
    input  logic                             wr_sel,
    input  logic [WORD_W-1:0]                wr_data,
    output logic [NUM_TRIG-1:0][WORD_W-1:0]  cap_hi,
    output logic [NUM_TRIG-1:0][WORD_W-1:0]  cap_lo,
    output logic [WORD_W-1:0]                evt_reg,
    output logic [WORD_W-1:0]                mask_reg,
    output logic                             irq
);
    localparam int HI_W = TIME_W - WORD_W;

    logic [NUM_TRIG-1:0] trig_edge;
    logic [WORD_W-1:0]   set_vec;
    logic                clr_wr;
    logic                mask_wr;

    // One detector and one capture pair per trigger.
    for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
        logic [HI_W-1:0] hi_w;

        tsu_trig_detect #(.SYNC_LEN(SYNC_LEN)) i_det (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin       (trig_pin[t]),
            .fall_sel  (trig_fall[t]),
            .edge_pulse(trig_edge[t])
        );

        tsu_capture #(.TIME_W(TIME_W), .WORD_W(WORD_W)) i_cap (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (trig_edge[t]),
            .time_in(cur_time),
            .cap_hi (hi_w),
            .cap_lo (cap_lo[t])
        );

        assign cap_hi[t] = WORD_W'(hi_w);
    end

    // Place each source strobe at its event bit position.
    always_comb begin
        set_vec = '0;
        for (int t = 0; t < NUM_TRIG; t++)  set_vec[trig_bit(t)]  = trig_edge[t];
        for (int a = 0; a < NUM_ALARM; a++) set_vec[alarm_bit(a)] = alarm_hit[a];
        for (int p = 0; p < NUM_PULSE; p++) set_vec[pulse_bit(p)] = pulse_hit[p];
    end

    // Decode the write target.
    always_comb begin
        clr_wr  = wr_en && (reg_sel_e'(wr_sel) == SEL_EVENT);
        mask_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_MASK);
    end

    tsu_event_regs #(.W(WORD_W)) i_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(set_vec),
        .clr_wr (clr_wr),
        .mask_wr(mask_wr),
        .wr_data(wr_data),
        .evt_q  (evt_reg),
        .mask_q (mask_reg),
        .irq    (irq)
    );
endmodule

// File: rtl/tsu_evt_checker.sv
// Module: tsu_evt_checker
// Property checks for ext_ts_event_unit, attached with bind below.
module tsu_evt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  edge_pulse,
    input logic [63:0] cur_time,
    input logic [1:0]  alarm_hit,
    input logic [1:0]  pulse_hit,
    input logic        wr_en,
    input logic        wr_sel,
    input logic [31:0] wr_data,
    input logic [31:0] cap_hi0,
    input logic [31:0] cap_lo0,
    input logic [31:0] evt_reg,
    input logic [31:0] mask_reg,
    input logic        irq
);
    // R3 / R10: a detected edge loads the sampled time.
    a_r3_capture_load: assert property (@(posedge clk) disable iff (!rst_n)
        edge_pulse[0] |=> ({cap_hi0, cap_lo0} == $past(cur_time)));

    // R3: without an edge the pair holds.
    a_r3_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_pulse[0] |=> ($stable(cap_hi0) && $stable(cap_lo0)));

    // R5: a pending event stays pending unless cleared.
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_reg[24] && !(wr_en && !wr_sel && wr_data[24])) |=> evt_reg[24]);

    // R6: writing a one with no new event clears the bit.
    a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && wr_data[7] && !pulse_hit[0]) |=> !evt_reg[7]);

    // R8: with an empty mask there is no interrupt.
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_reg == 32'h0) |-> !irq);

    // R9: a set colliding with a clear leaves the bit set.
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_hit[0] && wr_en && !wr_sel && wr_data[16]) |=> evt_reg[16]);

    // R9: same for a trigger capture.
    a_r9_trig_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_pulse[1] && wr_en && !wr_sel && wr_data[25]) |=> evt_reg[25]);
endmodule

bind ext_ts_event_unit tsu_evt_checker i_tsu_evt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_pulse(trig_edge),
    .cur_time  (cur_time),
    .alarm_hit (alarm_hit),
    .pulse_hit (pulse_hit),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .cap_hi0   (cap_hi[0]),
    .cap_lo0   (cap_lo[0]),
    .evt_reg   (evt_reg),
    .mask_reg  (mask_reg),
    .irq       (irq)
);

// File: tb/test_ext_ts_event_unit.sv
module test_ext_ts_event_unit;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       trig_pin = '0;
    logic [1:0]       trig_fall = '0;
    logic [63:0]      cur_time = 64'h0000_0100_0000_0000;
    logic [1:0]       alarm_hit = '0;
    logic [1:0]       pulse_hit = '0;
    logic             wr_en = 1'b0;
    logic             wr_sel = 1'b0;
    logic [31:0]      wr_data = '0;
    logic [1:0][31:0] cap_hi;
    logic [1:0][31:0] cap_lo;
    logic [31:0]      evt_reg;
    logic [31:0]      mask_reg;
    logic             irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ext_ts_event_unit i_ext_ts_event_unit (
        .clk(clk), .rst_n(rst_n), .trig_pin(trig_pin), .trig_fall(trig_fall),
        .cur_time(cur_time), .alarm_hit(alarm_hit), .pulse_hit(pulse_hit),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cap_hi(cap_hi), .cap_lo(cap_lo), .evt_reg(evt_reg),
        .mask_reg(mask_reg), .irq(irq)
    );

    // Behavioural reference state.
    bit     hist0[$];
    bit     hist1[$];
    logic [63:0] m_cap[2];
    logic [31:0] m_evt;
    logic [31:0] m_mask;
    localparam logic [31:0] IMPL = 32'h0303_00C0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit edge_of(input bit newer, input bit older, input bit fall);
        return fall ? (older & ~newer) : (newer & ~older);
    endfunction

    // Reference model, one update per clock edge.
    always @(posedge clk) begin
        logic [31:0] setv;
        logic [31:0] clrv;
        bit e0;
        bit e1;
        if (!rst_n) begin
            hist0 = '{0, 0, 0};
            hist1 = '{0, 0, 0};
            m_cap[0] = '0; m_cap[1] = '0;
            m_evt = '0; m_mask = '0;
        end else begin
            e0 = edge_of(hist0[1], hist0[2], trig_fall[0]);
            e1 = edge_of(hist1[1], hist1[2], trig_fall[1]);
            if (e0) m_cap[0] = cur_time;
            if (e1) m_cap[1] = cur_time;
            setv = '0;
            setv[24] = e0; setv[25] = e1;
            setv[16] = alarm_hit[0]; setv[17] = alarm_hit[1];
            setv[7] = pulse_hit[0]; setv[6] = pulse_hit[1];
            clrv = (wr_en && !wr_sel) ? wr_data : 32'h0;
            m_evt = ((m_evt & ~clrv) | setv) & IMPL;
            if (wr_en && wr_sel) m_mask = wr_data & IMPL;
            hist0.push_front(trig_pin[0]); void'(hist0.pop_back());
            hist1.push_front(trig_pin[1]); void'(hist1.pop_back());
        end
    end

    // Compare all outputs with the model on every falling edge; advance time.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 cap0", {cap_hi[0], cap_lo[0]}, m_cap[0]);
            chk("R3 cap1", {cap_hi[1], cap_lo[1]}, m_cap[1]);
            chk("R5 evt", {32'h0, evt_reg}, {32'h0, m_evt});
            chk("R7 mask", {32'h0, mask_reg}, {32'h0, m_mask});
            chk("R8 irq", {63'h0, irq}, {63'h0, |(m_evt & m_mask)});
        end
        cur_time <= cur_time + 64'h0000_0001_0000_0013;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input bit sel, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        logic [63:0] saved;
        cyc(3);
        chk("R1 evt", {32'h0, evt_reg}, 64'h0);
        chk("R1 mask", {32'h0, mask_reg}, 64'h0);
        chk("R1 cap", {cap_hi[0], cap_lo[0]} | {cap_hi[1], cap_lo[1]}, 64'h0);
        chk("R1 irq", {63'h0, irq}, 64'h0);
        rst_n = 1'b1;
        cyc(2);

        // R2: latency of a rising edge on trigger 0.
        trig_pin[0] = 1'b1;
        cyc(2);
        chk("R2 no early event", {63'h0, evt_reg[24]}, 64'h0);
        cyc(1);
        chk("R2 event after sync", {63'h0, evt_reg[24]}, 64'h1);
        chk("R3 cap0 matches model", {cap_hi[0], cap_lo[0]}, m_cap[0]);
        saved = {cap_hi[0], cap_lo[0]};
        trig_pin[0] = 1'b0;
        cyc(4);
        chk("R4 rising only, cap0 held", {cap_hi[0], cap_lo[0]}, saved);

        // R4: falling edge selection on trigger 1.
        trig_fall[1] = 1'b1;
        cyc(1);
        trig_pin[1] = 1'b1;
        cyc(4);
        chk("R4 rise ignored", {63'h0, evt_reg[25]}, 64'h0);
        trig_pin[1] = 1'b0;
        cyc(4);
        chk("R4 fall captured", {63'h0, evt_reg[25]}, 64'h1);

        // R6: write-one-to-clear, zeros keep.
        reg_write(1'b0, 32'h0000_0000);
        chk("R6 zero write keeps", {32'h0, evt_reg}, 64'h0300_0000);
        reg_write(1'b0, 32'h0200_0000);
        chk("R6 clear bit 25", {32'h0, evt_reg}, 64'h0100_0000);
        chk("R6 mask untouched", {32'h0, mask_reg}, 64'h0);

        // R5 / R7 / R8: other sources, masking.
        alarm_hit = 2'b11; pulse_hit = 2'b11;
        cyc(1);
        alarm_hit = '0; pulse_hit = '0;
        chk("R5 all sources", {32'h0, evt_reg}, 64'h0103_00C0);
        chk("R8 mask zero, no irq", {63'h0, irq}, 64'h0);
        reg_write(1'b1, 32'hFFFF_FFFF);
        chk("R7 only implemented bits", {32'h0, mask_reg}, 64'h0303_00C0);
        chk("R7 event untouched", {32'h0, evt_reg}, 64'h0103_00C0);
        reg_write(1'b1, 32'h0000_0040);
        chk("R8 irq from bit 6", {63'h0, irq}, 64'h1);
        reg_write(1'b0, 32'h0000_0040);
        chk("R8 irq drops", {63'h0, irq}, 64'h0);

        // R9: alarm strobe together with its clear.
        alarm_hit[0] = 1'b1; wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h0001_0000;
        cyc(1);
        alarm_hit[0] = 1'b0; wr_en = 1'b0; wr_data = '0;
        chk("R9 alarm set wins", {63'h0, evt_reg[16]}, 64'h1);

        // R9 / R10: trigger 0 capture together with clear of bit 24.
        trig_pin[0] = 1'b1;
        cyc(2);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h0100_0000;
        cyc(1);
        wr_en = 1'b0; wr_data = '0;
        chk("R9 trigger set wins", {63'h0, evt_reg[24]}, 64'h1);
        chk("R10 overwrite differs", {63'h0, ({cap_hi[0], cap_lo[0]} != saved)}, 64'h1);
        chk("R10 overwrite value", {cap_hi[0], cap_lo[0]}, m_cap[0]);

        // Trigger 1 capture colliding with its clear.
        trig_pin[1] = 1'b1;
        cyc(1);
        trig_pin[1] = 1'b0;
        cyc(2);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h0200_0000;
        cyc(1);
        wr_en = 1'b0; wr_data = '0;
        chk("R9 trigger 1 set wins", {63'h0, evt_reg[25]}, 64'h1);

        // Mixed traffic compared cycle by cycle.
        for (int i = 0; i < 200; i++) begin
            trig_pin  = 2'((i * 7) >> 2);
            trig_fall = 2'(i >> 5);
            alarm_hit = 2'(((i % 5) == 0) ? (i >> 3) : 0);
            pulse_hit = 2'(((i % 3) == 0) ? (i >> 1) : 0);
            wr_en   = (i % 4) == 1;
            wr_sel  = (i % 8) == 5;
            wr_data = 32'(i * 32'h0102_0A41);
            cyc(1);
        end
        wr_en = 1'b0;
        cyc(2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule